// File: doc/BRIEF.md
# Raster Interrupt Generator

This block turns the horizontal and vertical sync outputs of a display timing controller into a periodic interrupt request for a processor. It counts scan lines by watching for the end of each horizontal sync pulse. Every fifty-second line it raises a level request. The request stays up until the processor acknowledges it.

At the start of each frame the block realigns itself to the raster. A vertical sync rising edge arms a short two-line delay. When that delay runs out, the line count is cleared. If the count was still low at that moment, a request is raised as well, so the frame phase stays locked to vertical sync.

Software can zero the line count through a strobe. The acknowledge also drops bit 5 of the count, which holds back the next request when an acknowledge arrives late in a period.

Top module: `raster_irq_gen`

## Requirements
- R1: The line count advances by one for each falling edge of `hsync_in`, detected against its value one clock earlier. A pulse held high for many cycles counts once, and rising edges do not count.
- R2: On the line end that brings the count to 52, `irq_req` is set and the count returns to 0.
- R3: A rising edge of `vsync_in` loads a resync delay of 2 line ends. The resync takes place on the second `hsync_in` falling edge after that rising edge.
- R4: When the resync takes place, `irq_req` is set only if the line count, after that line end's step, is below 32. In both cases the count is cleared to 0.
- R5: A high `irq_ack` clears `irq_req` on the next clock edge and clears bit 5 (value 32) of the line count. A set in the same cycle wins over the clear.
- R6: A high `line_cnt_clr` zeroes the line count on the next clock edge. It takes priority over a line end in the same cycle.
- R7: `irq_req` is a level. Once set, it stays high through further line ends until it is acknowledged.
- R8: A synchronous active-high `rst` clears the line count, `irq_req`, the resync delay and the stored sync levels.
- R9: Events are sampled on a rising `clk` edge. `irq_req` reflects them right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync from the timing controller |
| vsync_in | input | 1 | Vertical sync from the timing controller |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| line_cnt_clr | input | 1 | Software strobe that zeroes the line count |
| irq_req | output | 1 | Level interrupt request |

## Verification
The bench checks the exact line on which the request appears, both after a plain 52-line period and after a long hsync pulse; a design that counted rising edges or levels would fire early. It acknowledges with a count of 40 pending and expects the next request 44 lines later; a design that cleared the whole count on acknowledge would wait 52 lines, and one that ignored bit 5 would fire after 12. It runs resync with counts on both sides of 32, expecting a request on the second line after vsync only in the low case and a fresh 52-line period in both. A design off by one in the delay, or one that left the count standing, shows up there. A reset taken while a resync is armed must leave no late request.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

    localparam int unsigned DEF_LINES_PER_IRQ = 52;
    localparam int unsigned DEF_RESYNC_DELAY  = 2;
    localparam int unsigned DEF_RESYNC_LIMIT  = 32;
    localparam int unsigned DEF_ACK_BIT       = 5;

    // Decoded sync events for one clock
    typedef struct packed {
        logic line_end;     // hsync falling edge
        logic frame_start;  // vsync rising edge
    } sync_evt_t;

    // Value of a vector with one bit forced low
    function automatic logic [31:0] drop_bit(input logic [31:0] v, input int unsigned pos);
        logic [31:0] r;
        r      = v;
        r[pos] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/rirq_edge_det.sv
module rirq_edge_det #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = level[i] & ~prev_q[i];
        assign fall[i] = ~level[i] & prev_q[i];

        // R1
        fall_follows_high_chk: assert property (@(posedge clk) disable iff (rst)
            fall[i] |-> $past(level[i]) || $past(rst));
    end
endmodule

// File: rtl/rirq_resync.sv
module rirq_resync
    import raster_irq_pkg::*;
#(
    parameter int unsigned RESYNC_DELAY = DEF_RESYNC_DELAY
) (
    input  logic      clk,
    input  logic      rst,
    input  sync_evt_t evt,
    output logic      fire
);
    localparam int unsigned DLY_W = $clog2(RESYNC_DELAY + 1);

    logic [DLY_W-1:0] dly_q;

    assign fire = evt.line_end && (dly_q == DLY_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
        end else if (evt.frame_start) begin
            dly_q <= DLY_W'(RESYNC_DELAY);
        end else if (evt.line_end && dly_q != '0) begin
            dly_q <= dly_q - 1'b1;
        end
    end

    // R3
    delay_load_chk: assert property (@(posedge clk) disable iff (rst)
        evt.frame_start |=> dly_q == DLY_W'(RESYNC_DELAY));

    // R3
    delay_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.frame_start && !evt.line_end |=> $stable(dly_q));
endmodule

// File: rtl/rirq_line_div.sv
module rirq_line_div
    import raster_irq_pkg::*;
#(
    parameter int unsigned LINES_PER_IRQ = DEF_LINES_PER_IRQ,
    parameter int unsigned RESYNC_LIMIT  = DEF_RESYNC_LIMIT,
    parameter int unsigned ACK_BIT       = DEF_ACK_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic line_end,
    input  logic resync,
    input  logic ack,
    input  logic soft_clr,
    output logic wrap,
    output logic below_limit
);
    localparam int unsigned CNT_W = $clog2(LINES_PER_IRQ + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] settled;
    logic [31:0]      masked;

    always_comb begin
        masked      = drop_bit(32'(cnt_q), ACK_BIT);
        base        = ack ? masked[CNT_W-1:0] : cnt_q;
        stepped     = line_end ? base + 1'b1 : base;
        wrap        = line_end && (stepped == CNT_W'(LINES_PER_IRQ));
        settled     = wrap ? '0 : stepped;
        below_limit = settled < CNT_W'(RESYNC_LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (soft_clr || resync) cnt_q <= '0;
        else                        cnt_q <= settled;
    end

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(LINES_PER_IRQ));

    // R6
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> cnt_q == '0);

    // R4
    resync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        resync |=> cnt_q == '0);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !line_end && !ack && !soft_clr && !resync |=> $stable(cnt_q));
endmodule

// File: rtl/rirq_flag.sv
module rirq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst)      req <= 1'b0;
        else if (set) req <= 1'b1;
        else if (clr) req <= 1'b0;
    end

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req && !clr |=> req);

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr && !set |=> !req);

    // R9
    set_visible_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> req);
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
    import raster_irq_pkg::*;
#(
    parameter int unsigned LINES_PER_IRQ = DEF_LINES_PER_IRQ,
    parameter int unsigned RESYNC_DELAY  = DEF_RESYNC_DELAY,
    parameter int unsigned RESYNC_LIMIT  = DEF_RESYNC_LIMIT,
    parameter int unsigned ACK_BIT       = DEF_ACK_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic irq_ack,
    input  logic line_cnt_clr,
    output logic irq_req
);
    logic [1:0] rise;
    logic [1:0] fall;
    sync_evt_t  evt;
    logic       resync;
    logic       wrap;
    logic       below_limit;

    rirq_edge_det #(.N(2)) u_edges (
        .clk   (clk),
        .rst   (rst),
        .level ({vsync_in, hsync_in}),
        .rise  (rise),
        .fall  (fall)
    );

    assign evt.line_end    = fall[0];
    assign evt.frame_start = rise[1];

    rirq_resync #(.RESYNC_DELAY(RESYNC_DELAY)) u_resync (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .fire (resync)
    );

    rirq_line_div #(
        .LINES_PER_IRQ (LINES_PER_IRQ),
        .RESYNC_LIMIT  (RESYNC_LIMIT),
        .ACK_BIT       (ACK_BIT)
    ) u_div (
        .clk         (clk),
        .rst         (rst),
        .line_end    (evt.line_end),
        .resync      (resync),
        .ack         (irq_ack),
        .soft_clr    (line_cnt_clr),
        .wrap        (wrap),
        .below_limit (below_limit)
    );

    rirq_flag u_flag (
        .clk (clk),
        .rst (rst),
        .set (wrap || (resync && below_limit)),
        .clr (irq_ack),
        .req (irq_req)
    );

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !irq_req);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_req && !evt.line_end |=> !irq_req);
endmodule

// File: tb/tb_raster_irq_gen.sv
module tb_raster_irq_gen;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst, hsync_in, vsync_in, irq_ack, line_cnt_clr;
    logic irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    raster_irq_gen dut (
        .clk          (clk),
        .rst          (rst),
        .hsync_in     (hsync_in),
        .vsync_in     (vsync_in),
        .irq_ack      (irq_ack),
        .line_cnt_clr (line_cnt_clr),
        .irq_req      (irq_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input logic exp, input string req);
        checks++;
        if (irq_req !== exp) begin
            failures++;
            $display("FAIL %s: irq_req actual=%b expected=%b", req, irq_req, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; hsync_in = 0; vsync_in = 0; irq_ack = 0; line_cnt_clr = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    // one line: hsync high for `hi` cycles then low for 2; the falling edge is seen
    // at the posedge after hsync drops, so irq_req is settled on return
    task automatic line(input int hi = 2);
        hsync_in = 1;
        for (int i = 0; i < hi; i++) @(negedge clk);
        hsync_in = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) line();
    endtask

    task automatic pulse_ack();
        irq_ack = 1; @(negedge clk); irq_ack = 0; @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(1'b0, "R8 reset state");
    endtask

    task automatic t_period();
        do_reset();
        line(12);                   // R1 long pulse counts once
        lines(50);
        check(1'b0, "R1 51 line ends, no request");
        line();
        check(1'b1, "R2 request on 52nd line");
        lines(3);
        check(1'b1, "R7 request held across lines");
        pulse_ack();
        check(1'b0, "R5 ack clears request");
        lines(48);
        check(1'b0, "R2 count restarted at wrap, line 51");
        line();
        check(1'b1, "R2 second period fires");
    endtask

    task automatic t_soft_clear();
        do_reset();
        lines(20);
        line_cnt_clr = 1; @(negedge clk); line_cnt_clr = 0; @(negedge clk);
        lines(51);
        check(1'b0, "R6 no request 51 lines after clear");
        line();
        check(1'b1, "R6 request 52 lines after clear");
    endtask

    task automatic t_ack_bit5();
        do_reset();
        lines(40);
        pulse_ack();                // count 40 -> 8
        lines(43);
        check(1'b0, "R5 bit 5 cleared, 43 lines later");
        line();
        check(1'b1, "R5 bit 5 cleared, request 44 lines later");
    endtask

    task automatic t_resync_low();
        do_reset();
        lines(10);
        vsync_in = 1; @(negedge clk);
        line();
        check(1'b0, "R3 no resync on first line after vsync");
        line();
        check(1'b1, "R4 resync request with count below 32");
        vsync_in = 0;
        pulse_ack();
        lines(51);
        check(1'b0, "R4 count cleared by resync, line 51");
        line();
        check(1'b1, "R4 next request 52 lines after resync");
    endtask

    task automatic t_resync_high();
        do_reset();
        lines(35);
        vsync_in = 1; @(negedge clk);
        lines(2);
        check(1'b0, "R4 no resync request with count 37");
        vsync_in = 0;
        lines(51);
        check(1'b0, "R4 count cleared at resync, line 51");
        line();
        check(1'b1, "R4 request 52 lines after resync");
    endtask

    task automatic t_reset_mid();
        do_reset();
        lines(30);
        vsync_in = 1; @(negedge clk); vsync_in = 0; @(negedge clk);
        do_reset();
        check(1'b0, "R8 request low after reset");
        lines(2);
        check(1'b0, "R8 reset dropped armed resync");
        lines(49);
        check(1'b0, "R8 count cleared, line 51");
        line();
        check(1'b1, "R8 request after full period");
    endtask

    initial begin
        rst = 1; hsync_in = 0; vsync_in = 0; irq_ack = 0; line_cnt_clr = 0;
        t_reset_state();
        t_period();
        t_soft_clear();
        t_ack_bit5();
        t_resync_low();
        t_resync_high();
        t_reset_mid();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule